// File: doc/BRIEF.md
# Long-Burst Serial Peripheral Master

This block is a serial peripheral master that software drives through a small four-register bus. Software writes 32-bit words into a transmit queue. The block shifts them out on MOSI while it captures MISO into a receive queue. One of four active-low chip selects frames each burst. The burst length is programmable in bits and may exceed one 32-bit word. When it does, the first queued word carries only the leftover bits at its low end, and every later word carries a full 32 bits. Bits leave most significant first, so the earliest byte of a stream sits in the upper byte of its word, and received words fill the same way.

The link runs in the idle-low clock mode: MOSI changes on the falling SCLK edge and MISO is sampled on the rising edge. SCLK is the system clock divided by an even programmable ratio. Clearing the enable bit acts as a soft reset for everything except the control register. While the block is disabled, it refuses writes to the other registers, answers reads with reset values and holds every chip select high.

Register map (two-bit address): 0 control, 1 status, 2 transmit data (write pushes), 3 receive data (read with the read strobe pops).

Top module: `spi_burst_master`

## Requirements
- R1: Control bits [27:16] hold the burst length in bits minus one. The block rounds the length up to a multiple of 8, so 11 gives 16 bits and 0x020 gives 40 bits.
- R2: A burst that spans several words takes (length mod 32) bits from the low end of the first transmit word, then 32 bits from each following word. A 48-bit burst therefore takes 16 bits, then 32 bits. Received words are split the same way, and a partial word is right-aligned with zeros above it.
- R3: Each word is shifted out most significant bit first, and received bits enter the receive word from its least significant end, so byte order is big-endian.
- R4: While control bit 0 (enable) is clear, writes to addresses 1, 2 and 3 have no effect.
- R5: While disabled, status reads return 0x1 and receive-data reads return 0.
- R6: The control register reads 0 after reset. Clearing enable empties both queues and clears the status flags, while the control value is kept.
- R7: In the cycle after enable is cleared, all chip selects are high and SCLK is low, and they stay that way while the block is disabled.
- R8: Control bits [2:1] pick the chip select, and only that line is driven low, for the whole burst.
- R9: SCLK is low for DIV+1 and high for DIV+1 system clocks, where DIV is control bits [15:8].
- R10: The chip select rises 2*(DIV+1) system clocks after the last falling SCLK edge of the burst.
- R11: Status bit 0 is transmit empty, bit 1 transmit full, bit 2 receive data ready and bit 3 receive overflow. Each queue holds 8 words. A received word that arrives while the receive queue is full is dropped and sets bit 3.
- R12: A burst starts one clock after the transmit queue becomes non-empty while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe (pops receive data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
Register writes take effect at the next clock edge. Chip-select release on disable is therefore due at the first falling clock edge after the write, and the bench checks the outputs there on every cycle. The first chip-select fall is due one clock after the transmit push. Its end is found by waiting for all selects to return high, after which the bench compares the captured MOSI stream and the received words with streams computed from the length rule. SCLK period and chip-select hold are measured as time differences between observed edges, and each is compared with a multiple of the 20 ns clock.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = 12,
  parameter int NCS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wen,
  input  logic        reg_ren,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [NCS-1:0] cs_n
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int CSW = $clog2(NCS);
  localparam int HW  = DIV_W + 1;

  typedef enum logic [2:0] {IDLE, LOW, HIGH, WAITW, TAIL} st_t;

  logic [31:0] ctrl;
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic ovf, sclk_q;
  st_t st;
  logic [HW-1:0] hcnt;
  logic [31:0] tx_sh, rx_sh;
  logic [4:0] bcnt;
  logic [LEN_W-1:0] wleft;
  logic [CSW-1:0] csq;

  wire              en   = ctrl[0];
  wire [CSW-1:0]    sel  = ctrl[1 +: CSW];
  wire [DIV_W-1:0]  div  = ctrl[8 +: DIV_W];
  wire [LEN_W-1:0]  blen = ctrl[16 +: LEN_W];

  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire half_done = hcnt == {1'b0, div};
  wire word_end  = st == HIGH && half_done && bcnt == 5'd0;
  wire tx_push = en && reg_wen && reg_addr == 2'd2 && !tx_full;
  wire rx_pop  = en && reg_ren && reg_addr == 2'd3 && rx_cnt != '0;
  wire tx_pop  = en && !tx_empty && (st == IDLE || st == WAITW || (word_end && wleft != '0));
  wire rx_push = en && word_end;
  wire rx_wr   = rx_push && !rx_full;

  wire [4:0] low5 = 5'(blen[4:0] | 5'd7) + 5'd1;
  wire [5:0] rbits = (low5 == 5'd0) ? 6'd32 : {1'b0, low5};

  always_ff @(posedge clk)
    if (!rst_n) ctrl <= '0;
    else if (reg_wen && reg_addr == 2'd0) ctrl <= reg_wdata;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_wr) rx_mem[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st <= IDLE; hcnt <= '0; sclk_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
      bcnt <= '0; wleft <= '0; csq <= '0; ovf <= 1'b0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      tx_wp  <= tx_wp + AW'(tx_push);
      tx_rp  <= tx_rp + AW'(tx_pop);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_wp  <= rx_wp + AW'(rx_wr);
      rx_rp  <= rx_rp + AW'(rx_pop);
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_pop);
      ovf    <= ovf | (rx_push & rx_full);
      case (st)
        IDLE: if (tx_pop) begin
          st <= LOW; hcnt <= '0; csq <= sel; rx_sh <= '0;
          bcnt  <= 5'(rbits - 6'd1);
          tx_sh <= tx_mem[tx_rp] << (6'd32 - rbits);
          wleft <= (blen | LEN_W'(7)) >> 5;
        end
        LOW: if (half_done) begin
          sclk_q <= 1'b1; rx_sh <= {rx_sh[30:0], miso}; hcnt <= '0; st <= HIGH;
        end else hcnt <= hcnt + HW'(1);
        HIGH: if (half_done) begin
          sclk_q <= 1'b0; hcnt <= '0;
          if (bcnt != 5'd0) begin
            bcnt <= bcnt - 5'd1; tx_sh <= tx_sh << 1; st <= LOW;
          end else begin
            rx_sh <= '0;
            if (wleft != '0) begin
              wleft <= wleft - LEN_W'(1);
              if (tx_pop) begin
                tx_sh <= tx_mem[tx_rp]; bcnt <= 5'd31; st <= LOW;
              end else st <= WAITW;
            end else st <= TAIL;
          end
        end else hcnt <= hcnt + HW'(1);
        WAITW: if (tx_pop) begin
          tx_sh <= tx_mem[tx_rp]; bcnt <= 5'd31; hcnt <= '0; st <= LOW;
        end
        TAIL: if (hcnt == {div, 1'b1}) begin
          st <= IDLE; hcnt <= '0;
        end else hcnt <= hcnt + HW'(1);
        default: st <= IDLE;
      endcase
    end
  end

  assign sclk = sclk_q & en;
  assign mosi = en && st != IDLE && tx_sh[31];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(en && st != IDLE && csq == CSW'(i));
  end

  always_comb
    case (reg_addr)
      2'd0: reg_rdata = ctrl;
      2'd1: reg_rdata = en ? {28'd0, ovf, rx_cnt != '0, tx_full, tx_empty} : 32'h1;
      2'd3: reg_rdata = (en && rx_cnt != '0) ? rx_mem[rx_rp] : 32'h0;
      default: reg_rdata = 32'h0;
    endcase

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 2'd0 && !reg_wdata[0]) |=> (&cs_n && !sclk));
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  // R11
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH));
  // R11
  rx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !(reg_wen && reg_addr == 2'd0)) |=> ovf);
  // R4
  dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && reg_wen && reg_addr == 2'd2) |=> tx_empty);
endmodule

// File: tb/sim_spi_burst_master.sv
module sim_spi_burst_master;
  typedef bit bq_t[$];
  typedef logic [31:0] wq_t[$];
  localparam real TP = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wen = 1'b0, reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  spi_burst_master u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int checks = 0, errors = 0, pc_checks = 0, pc_errors = 0;
  bit exp_en = 1'b0;
  bit mbits [256];
  bit gbits [256];
  int nrise = 0;
  realtime t_rise = 0, t_rise_prev = 0, t_fall = 0, t_csup = 0;
  wire cs_idle = &cs_n;

  always @(posedge sclk or negedge cs_idle)
    if (sclk) begin
      if (nrise < 256) gbits[nrise] <= mosi;
      nrise <= nrise + 1;
      t_rise_prev <= t_rise;
      t_rise <= $realtime;
    end else nrise <= 0;
  always @(negedge sclk) t_fall <= $realtime;
  always @(posedge cs_idle) t_csup <= $realtime;
  assign miso = (nrise < 256) ? mbits[nrise] : 1'b0;

  always @(negedge clk)
    if (rst_n) begin
      pc_checks++;
      if ($countones(~cs_n) > 1) begin
        pc_errors++;
        $display("FAIL R8 several selects low actual=%b expected=one or none", cs_n);
      end
      if (!exp_en) begin
        pc_checks++;
        if (!(cs_n == 4'hF && !sclk)) begin
          pc_errors++;
          $display("FAIL R7 disabled outputs actual=%b/%b expected=1111/0", cs_n, sclk);
        end
      end
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); if (a == 2'd0) exp_en = d[0];
    #1 reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_ren = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_ren = 1'b0;
  endtask

  function automatic int blen_bits(input int blen);
    return ((blen + 8) / 8) * 8;
  endfunction

  function automatic bq_t expand(input int blen, input wq_t w);
    bq_t q; int L = blen_bits(blen); int r = L % 32; int nw = (L + 31) / 32;
    if (r == 0) r = 32;
    for (int k = 0; k < nw; k++)
      for (int i = ((k == 0) ? r : 32) - 1; i >= 0; i--) q.push_back(w[k][i]);
    return q;
  endfunction

  function automatic wq_t pack(input int blen, input bq_t b);
    wq_t o; int L = blen_bits(blen); int r = L % 32; int nw = (L + 31) / 32; int idx = 0;
    if (r == 0) r = 32;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] v = '0;
      for (int i = 0; i < ((k == 0) ? r : 32); i++) begin v = {v[30:0], b[idx]}; idx++; end
      o.push_back(v);
    end
    return o;
  endfunction

  function automatic logic [31:0] cfg(input int div, input int sel, input int blen);
    return 32'h1 | (32'(sel) << 1) | (32'(div) << 8) | (32'(blen) << 16);
  endfunction

  task automatic burst(input int div, input int sel, input int blen,
                       input wq_t tw, input wq_t mw, input string req);
    bq_t eb = expand(blen, tw);
    bq_t mb = expand(blen, mw);
    wq_t er = pack(blen, mb);
    logic [31:0] v;
    int bad = -1;
    foreach (mb[i]) mbits[i] = mb[i];
    wr(2'd0, cfg(div, sel, blen));
    foreach (tw[i]) wr(2'd2, tw[i]);
    wait (cs_idle == 1'b0);
    @(negedge clk);
    chk(cs_n == ~(4'b1 << sel), "R8", "selected line", {28'd0, cs_n}, {28'd0, ~(4'b1 << sel)});
    wait (cs_idle == 1'b1);
    repeat (3) @(negedge clk);
    chk(nrise == eb.size(), "R1", "SCLK pulses", nrise, eb.size());
    foreach (eb[i]) if (bad < 0 && gbits[i] != eb[i]) bad = i;
    chk(bad < 0, req, "MOSI stream first bad bit", bad, 32'hFFFFFFFF);
    chk(t_rise - t_rise_prev == 2.0 * (div + 1) * TP, "R9", "SCLK period",
        int'((t_rise - t_rise_prev) / TP), 2 * (div + 1));
    chk(t_csup - t_fall == 2.0 * (div + 1) * TP, "R10", "select hold",
        int'((t_csup - t_fall) / TP), 2 * (div + 1));
    foreach (er[i]) begin
      rd(2'd3, v);
      chk(v == er[i], req, "RX word", v, er[i]);
    end
  endtask

  initial begin
    #(200000 * 20);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks + pc_checks + 1, errors + pc_errors + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wq_t tw, mw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF && !sclk, "R7", "reset outputs", {cs_n, 3'd0, sclk}, 32'hF0);
    rd(2'd0, v); chk(v == 32'h0, "R6", "control after reset", v, 32'h0);
    rd(2'd1, v); chk(v == 32'h1, "R5", "status while disabled", v, 32'h1);

    // R4: data written while disabled is lost; R12: start one clock after push
    wr(2'd2, 32'h000000FF);
    wr(2'd0, cfg(0, 0, 7));
    repeat (6) @(negedge clk);
    chk(cs_n == 4'hF, "R4", "no burst from ignored write", {28'd0, cs_n}, 32'hF);
    rd(2'd1, v); chk(v == 32'h1, "R4", "status after ignored write", v, 32'h1);
    for (int i = 0; i < 8; i++) mbits[i] = 1'b0;
    wr(2'd2, 32'h00000055);
    @(negedge clk);
    chk(cs_n == 4'hF, "R12", "select before load", {28'd0, cs_n}, 32'hF);
    @(negedge clk);
    chk(cs_n == 4'hE, "R12", "select one clock after push", {28'd0, cs_n}, 32'hE);
    wait (cs_idle == 1'b1);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk(v == 32'h5, "R11", "status with RX data", v, 32'h5);
    wr(2'd0, 32'h0);
    rd(2'd1, v); chk(v == 32'h1, "R5", "status read disabled", v, 32'h1);
    rd(2'd3, v); chk(v == 32'h0, "R5", "RX read disabled", v, 32'h0);
    wr(2'd0, cfg(0, 0, 7));
    rd(2'd1, v); chk(v == 32'h1, "R6", "queues cleared by disable", v, 32'h1);

    tw = {32'h000000A5}; mw = {32'h0000003C};
    burst(0, 0, 7, tw, mw, "R3");
    tw = {32'h12345678}; mw = {32'hC0FFEE11};
    burst(1, 1, 31, tw, mw, "R3");
    tw = {32'hAAAA1234, 32'hDEADBEEF}; mw = {32'h0000F00D, 32'h01234567};
    burst(0, 2, 47, tw, mw, "R2");
    tw = {32'h5A5A5A77, 32'h89ABCDEF}; mw = {32'h000000E1, 32'h13579BDF};
    burst(2, 3, 32'h20, tw, mw, "R1");
    tw = {32'h0000BEEF}; mw = {32'h00004242};
    burst(0, 0, 11, tw, mw, "R1");

    // R7 disable in the middle of a burst, R6 control kept
    wr(2'd0, cfg(3, 1, 31));
    wr(2'd2, 32'hCAFEF00D);
    wait (cs_idle == 1'b0);
    repeat (10) @(negedge clk);
    wr(2'd0, cfg(3, 1, 31) & ~32'h1);
    @(negedge clk);
    chk(cs_n == 4'hF && !sclk, "R7", "release on disable", {cs_n, 3'd0, sclk}, 32'hF0);
    rd(2'd0, v); chk(v == (cfg(3, 1, 31) & ~32'h1), "R6", "control kept", v, cfg(3, 1, 31) & ~32'h1);
    wr(2'd0, cfg(0, 0, 7));
    rd(2'd1, v); chk(v == 32'h1, "R6", "status after abort", v, 32'h1);

    // R11 transmit full
    wr(2'd0, cfg(255, 0, 7));
    for (int i = 0; i < 9; i++) wr(2'd2, 32'(i));
    rd(2'd1, v); chk(v == 32'h2, "R11", "TX full status", v, 32'h2);
    wr(2'd0, 32'h0);
    wr(2'd0, cfg(0, 0, 7));

    // R11 overflow: nine words into an eight-deep queue
    for (int i = 0; i < 8; i++) mbits[i] = (8'h96 >> (7 - i)) & 1'b1;
    for (int i = 0; i < 9; i++) wr(2'd2, 32'(i));
    repeat (400) @(negedge clk);
    rd(2'd1, v); chk(v == 32'hD, "R11", "overflow status", v, 32'hD);
    rd(2'd3, v); chk(v == 32'h96, "R11", "kept RX word", v, 32'h96);
    wr(2'd0, 32'h0);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks + pc_checks, errors + pc_errors);
    $finish;
  end
endmodule